// File: doc/BRIEF.md
# Interval Timer and Interrupt Status Register Block

This block is the interrupt and timer corner of a small multiprocessor system controller. Software reaches it through a plain 32-bit register bus inside a 4 KiB window of word-addressed registers. It holds a down-counting interval timer, an external interrupt mask, a read-only processor identifier and a set of interrupt status registers. Reading a status register acknowledges the interrupt line it belongs to.

The interval timer is paced by a free-running prescaler that emits one tick every 2^TICK_SHIFT clock cycles. On each tick the counter steps down by one, but only when the reload value, the live count and the mask register are all nonzero and the values are treated as signed.

- When a step brings the count to zero, the timer interrupt rises.
- The timer interrupt stays high until software reads the timer status register.
- That read also reloads the counter, so the timer is re-armed.

The block also produces two more interrupt outputs:

- **Local-bus interrupt:** a registered copy of an external pending input.
- **Inter-processor interrupt:** latched from a request pulse and cleared by a status read.

Top module: `sysctl_irq_timer`

Register map, as byte offsets. The two low address bits are ignored.

| Offset | Register | Access and effect |
|---|---|---|
| 0x000 | configuration | reads 0, writes ignored |
| 0x004 | local-bus status | read only |
| 0x008 | PCI/EISA status | reads 0 |
| 0x00C | timer status | read acknowledges the timer interrupt |
| 0x010 | inter-processor status | read acknowledges the inter-processor interrupt |
| 0x014 | processor identifier | read only |
| 0x018 | mask | read/write |
| 0x01C | timer value | read/write |

## Requirements
- R1: After reset, all three interrupt outputs are 0, and the mask (0x018) and timer value (0x01C) registers read 0.
- R2: With the mask nonzero and a positive value N written to 0x01C, the timer interrupt rises after N prescaler ticks. One tick occurs every 2^TICK_SHIFT clock cycles, so the rise comes between (N-1) and N tick periods after the write.
- R3: The counter does not move, and the timer interrupt stays low, if the mask is 0 or the reload value is not positive as a signed number (0 or with bit 31 set).
- R4: A write to 0x01C loads both the reload register and the live counter. A read of 0x01C returns the reload value, not the live count.
- R5: The timer interrupt stays high until 0x00C is read. That read returns 0, drops the interrupt by the next sampling point, and reloads the counter, so the interrupt rises again after another N ticks.
- R6: A read of 0x004 returns 36 ((8+1)<<2) while the local-bus input is high and 0 while it is low. The local-bus interrupt output follows that input one cycle later.
- R7: A pulse on the inter-processor request sets the inter-processor interrupt. A read of 0x010 returns 0 and clears it.
- R8: The mask at 0x018 reads back what was written. 0x014 returns the cpu_id input. 0x000 and 0x008 read 0. Writes to 0x000 and to unmapped offsets change no register, and unmapped offsets read 0.
- R9: Read data appears on bus_rdata in the cycle after bus_rd_en and is 0 in any cycle that follows a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address within the window |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| cpu_id | input | 32 | Identifier of this processor |
| lb_irq_in | input | 1 | Local-bus interrupt pending |
| ipi_req | input | 1 | Inter-processor interrupt request pulse |
| irq_timer | output | 1 | Interval-timer interrupt |
| irq_lb | output | 1 | Local-bus interrupt |
| irq_ipi | output | 1 | Inter-processor interrupt |

## Verification
A live count that goes wrong only shows up as a timer interrupt that rises too early, too late or never, so the bench brackets each rise within a window of one tick period. It also keeps watching for several periods wherever the gating says the count must stay frozen. A reload lost on acknowledge shows up as a missing second rise within the next N ticks. Errors in the mask or pending flags appear on the very next read or on the interrupt pin one cycle after the stimulus.

// File: rtl/sct_pkg.sv
// Package: shared constants for the system-controller timer block.
// Holds the word indices of the register window and the fixed
// local-bus status code. Assumes a 32-bit word-addressed register bus.
package sct_pkg;
    localparam int unsigned SCT_DATA_W   = 32;
    localparam int unsigned SCT_WIN_BYTES = 4096;

    // Word indices (byte offset / 4); software depends on these.
    localparam int unsigned W_CONFIG  = 0;
    localparam int unsigned W_ST_LB   = 1;
    localparam int unsigned W_ST_PCI  = 2;
    localparam int unsigned W_ST_TMR  = 3;
    localparam int unsigned W_ST_IPI  = 4;
    localparam int unsigned W_CPU_ID  = 5;
    localparam int unsigned W_MASK    = 6;
    localparam int unsigned W_TMR_VAL = 7;

    // Encoded level returned for a pending local-bus interrupt.
    localparam logic [SCT_DATA_W-1:0] LB_LEVEL_CODE = 32'((8 + 1) << 2);

    typedef enum logic [3:0] {
        SEL_NONE, SEL_CONFIG, SEL_ST_LB, SEL_ST_PCI, SEL_ST_TMR,
        SEL_ST_IPI, SEL_CPU_ID, SEL_MASK, SEL_TMR_VAL
    } reg_sel_e;
endpackage

// File: rtl/sct_prescaler.sv
// Module: sct_prescaler
// Emits a one-cycle tick every 2^TICK_SHIFT clock cycles. The counter
// is free running from reset. TICK_SHIFT of 0 gives a tick every cycle.
module sct_prescaler #(
    parameter int unsigned TICK_SHIFT = 14
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (TICK_SHIFT == 0) begin : g_every_cycle
            assign tick = rst_n;
        end else begin : g_divider
            logic [TICK_SHIFT-1:0] div_q;

            // Free-running divider counter.
            always_ff @(posedge clk) begin
                if (!rst_n) div_q <= '0;
                else        div_q <= div_q + 1'b1;
            end

            assign tick = &div_q;

            // A tick never lasts two cycles.
            assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/sct_interval_timer.sv
// Module: sct_interval_timer
// Holds the reload register and the live down-counter, plus the latched
// timer interrupt. Assumes load and ack are single-cycle strobes from the
// register decoder. Priority is load, then ack, then tick.
module sct_interval_timer #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              gate_en,
    input  logic              load_we,
    input  logic [DATA_W-1:0] load_val,
    input  logic              ack,
    output logic [DATA_W-1:0] reload_q,
    output logic              irq_q
);
    logic [DATA_W-1:0] count_q;
    logic              dec_en;
    logic              hits_zero;

    // Decide whether this cycle performs a countdown step.
    always_comb begin
        dec_en    = tick && gate_en && !load_we && !ack
                    && ($signed(reload_q) > 0) && ($signed(count_q) > 0);
        hits_zero = dec_en && (count_q == DATA_W'(1));
    end

    // Reload register: written only by the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)       reload_q <= '0;
        else if (load_we) reload_q <= load_val;
    end

    // Live counter: load, reload on ack, or one step per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       count_q <= '0;
        else if (load_we) count_q <= load_val;
        else if (ack)     count_q <= reload_q;
        else if (dec_en)  count_q <= count_q - 1'b1;
    end

    // Interrupt latch: set on expiry, cleared only by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)         irq_q <= 1'b0;
        else if (ack)       irq_q <= 1'b0;
        else if (hits_zero) irq_q <= 1'b1;
    end

    assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q && !ack |=> irq_q);
    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !irq_q);
    assert_gate_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en && !load_we && !ack |=> $stable(count_q));
    assert_load_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> (count_q == reload_q));
endmodule

// File: rtl/sct_reg_file.sv
// Module: sct_reg_file
// Decodes the register window and holds the mask, the inter-processor
// pending flag and the local-bus flag. Produces timer load and ack strobes
// and registered read data. Assumes rd and wr target different registers
// when both are active.
module sct_reg_file
    import sct_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd_en,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] cpu_id,
    input  logic              lb_irq_in,
    input  logic              ipi_req,
    input  logic [DATA_W-1:0] tmr_reload,
    output logic              tmr_load_we,
    output logic              tmr_ack,
    output logic              gate_en,
    output logic              irq_lb,
    output logic              irq_ipi
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  word_idx;
    reg_sel_e          sel;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] rd_mux;
    logic              ipi_ack;

    assign word_idx = bus_addr[ADDR_W-1:2];

    // Map the word index to a register selector.
    always_comb begin
        unique case (word_idx)
            IDX_W'(W_CONFIG):  sel = SEL_CONFIG;
            IDX_W'(W_ST_LB):   sel = SEL_ST_LB;
            IDX_W'(W_ST_PCI):  sel = SEL_ST_PCI;
            IDX_W'(W_ST_TMR):  sel = SEL_ST_TMR;
            IDX_W'(W_ST_IPI):  sel = SEL_ST_IPI;
            IDX_W'(W_CPU_ID):  sel = SEL_CPU_ID;
            IDX_W'(W_MASK):    sel = SEL_MASK;
            IDX_W'(W_TMR_VAL): sel = SEL_TMR_VAL;
            default:           sel = SEL_NONE;
        endcase
    end

    // Side-effect strobes for the timer and inter-processor flag.
    always_comb begin
        tmr_load_we = bus_wr_en && (sel == SEL_TMR_VAL);
        tmr_ack     = bus_rd_en && (sel == SEL_ST_TMR);
        ipi_ack     = bus_rd_en && (sel == SEL_ST_IPI);
        gate_en     = (mask_q != '0);
    end

    // Mask register: the only plain read/write storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                             mask_q <= '0;
        else if (bus_wr_en && sel == SEL_MASK)  mask_q <= bus_wdata;
    end

    // Inter-processor pending flag: a request wins over a same-cycle ack.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_ipi <= 1'b0;
        else if (ipi_req) irq_ipi <= 1'b1;
        else if (ipi_ack) irq_ipi <= 1'b0;
    end

    // Local-bus interrupt output: registered copy of the pending input.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_lb <= 1'b0;
        else        irq_lb <= lb_irq_in;
    end

    // Read multiplexer over all selectors.
    always_comb begin
        unique case (sel)
            SEL_ST_LB:   rd_mux = lb_irq_in ? LB_LEVEL_CODE : '0;
            SEL_CPU_ID:  rd_mux = cpu_id;
            SEL_MASK:    rd_mux = mask_q;
            SEL_TMR_VAL: rd_mux = tmr_reload;
            default:     rd_mux = '0;
        endcase
    end

    // Registered read data, zero in cycles that follow no read.
    always_ff @(posedge clk) begin
        if (!rst_n)         bus_rdata <= '0;
        else if (bus_rd_en) bus_rdata <= rd_mux;
        else                bus_rdata <= '0;
    end

    assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |=> (bus_rdata == '0));
    assert_ipi_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ipi_ack && !ipi_req |=> !irq_ipi);
    assert_ipi_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ipi_req |=> irq_ipi);
endmodule

// File: rtl/sysctl_irq_timer.sv
// Module: sysctl_irq_timer
// Top of the system-controller interval timer and interrupt status block.
// Wires the prescaler, the interval timer and the register file together.
// Assumes a single clock domain and synchronous active-low reset.
module sysctl_irq_timer #(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned TICK_SHIFT = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd_en,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] cpu_id,
    input  logic              lb_irq_in,
    input  logic              ipi_req,
    output logic              irq_timer,
    output logic              irq_lb,
    output logic              irq_ipi
);
    logic              tick;
    logic              gate_en;
    logic              tmr_load_we;
    logic              tmr_ack;
    logic [DATA_W-1:0] tmr_reload;

    sct_prescaler #(.TICK_SHIFT(TICK_SHIFT)) u_prescaler (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    sct_interval_timer #(.DATA_W(DATA_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .gate_en (gate_en),
        .load_we (tmr_load_we),
        .load_val(bus_wdata),
        .ack     (tmr_ack),
        .reload_q(tmr_reload),
        .irq_q   (irq_timer)
    );

    sct_reg_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr_en  (bus_wr_en),
        .bus_wdata  (bus_wdata),
        .bus_rd_en  (bus_rd_en),
        .bus_rdata  (bus_rdata),
        .cpu_id     (cpu_id),
        .lb_irq_in  (lb_irq_in),
        .ipi_req    (ipi_req),
        .tmr_reload (tmr_reload),
        .tmr_load_we(tmr_load_we),
        .tmr_ack    (tmr_ack),
        .gate_en    (gate_en),
        .irq_lb     (irq_lb),
        .irq_ipi    (irq_ipi)
    );

    assert_outputs_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!irq_timer && !irq_lb && !irq_ipi && bus_rdata == '0));
endmodule

// File: tb/test_sysctl_irq_timer.sv
// Directed bench for sysctl_irq_timer. A short prescaler keeps runs brief.
module test_sysctl_irq_timer;
    localparam int unsigned TS = 4;
    localparam int unsigned P  = 1 << TS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd_en = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] cpu_id = 32'h0000_0017;
    logic        lb_irq_in = 1'b0;
    logic        ipi_req = 1'b0;
    logic        irq_timer, irq_lb, irq_ipi;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    sysctl_irq_timer #(.TICK_SHIFT(TS)) i_sysctl_irq_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
        .cpu_id(cpu_id), .lb_irq_in(lb_irq_in), .ipi_req(ipi_req),
        .irq_timer(irq_timer), .irq_lb(irq_lb), .irq_ipi(irq_ipi)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1'b1;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    // Count negedges until irq_timer is high, up to a limit.
    task automatic wait_irq(input int limit, output int n);
        n = 0;
        while (!irq_timer && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1", "irq_timer", 32'(irq_timer), 0);
        check("R1", "irq_lb", 32'(irq_lb), 0);
        check("R1", "irq_ipi", 32'(irq_ipi), 0);
        rd(12'h018, d); check("R1", "mask", d, 0);
        rd(12'h01C, d); check("R1", "timer value", d, 0);
    endtask

    task automatic t_expiry;
        logic [31:0] d;
        int n;
        wr(12'h018, 32'h1);
        wr(12'h01C, 32'd3);
        rd(12'h01C, d); check("R4", "reload readback", d, 32'd3);
        wait_irq(10 * P, n);
        n += 1;
        check("R2", "irq within window", 32'((n >= 2 * P - 1) && (n <= 3 * P + 2)), 1);
        repeat (3 * P) @(negedge clk);
        check("R5", "irq held until ack", 32'(irq_timer), 1);
        rd(12'h00C, d);
        check("R5", "timer status value", d, 0);
        check("R5", "irq cleared by ack", 32'(irq_timer), 0);
        wait_irq(10 * P, n);
        n += 1;
        check("R5", "re-armed irq window", 32'((n >= 2 * P - 1) && (n <= 3 * P + 2)), 1);
        rd(12'h00C, d);
    endtask

    task automatic t_gating;
        logic [31:0] d;
        wr(12'h018, 32'h0);
        wr(12'h01C, 32'd2);
        repeat (6 * P) @(negedge clk);
        check("R3", "mask zero freezes", 32'(irq_timer), 0);
        wr(12'h018, 32'h4);
        wr(12'h01C, 32'h8000_0000);
        repeat (6 * P) @(negedge clk);
        check("R3", "negative reload freezes", 32'(irq_timer), 0);
        wr(12'h01C, 32'h0);
        repeat (6 * P) @(negedge clk);
        check("R3", "zero reload freezes", 32'(irq_timer), 0);
        rd(12'h01C, d); check("R4", "reload readback zero", d, 0);
    endtask

    task automatic t_local_bus;
        logic [31:0] d;
        @(negedge clk); lb_irq_in = 1'b1;
        rd(12'h004, d); check("R6", "lb status pending", d, 32'd36);
        check("R6", "irq_lb high", 32'(irq_lb), 1);
        @(negedge clk); lb_irq_in = 1'b0;
        rd(12'h004, d); check("R6", "lb status idle", d, 0);
        check("R6", "irq_lb low", 32'(irq_lb), 0);
    endtask

    task automatic t_ipi;
        logic [31:0] d;
        @(negedge clk); ipi_req = 1'b1;
        @(negedge clk); ipi_req = 1'b0;
        check("R7", "ipi set", 32'(irq_ipi), 1);
        rd(12'h010, d); check("R7", "ipi status value", d, 0);
        check("R7", "ipi cleared", 32'(irq_ipi), 0);
    endtask

    task automatic t_misc;
        logic [31:0] d;
        wr(12'h018, 32'hA5A5_5A5A);
        rd(12'h018, d); check("R8", "mask readback", d, 32'hA5A5_5A5A);
        rd(12'h014, d); check("R8", "cpu id", d, 32'h0000_0017);
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000, d); check("R8", "config reads 0", d, 0);
        rd(12'h008, d); check("R8", "pci status 0", d, 0);
        wr(12'h200, 32'h1234_5678);
        rd(12'h200, d); check("R8", "unmapped reads 0", d, 0);
        rd(12'h018, d); check("R8", "mask untouched", d, 32'hA5A5_5A5A);
        rd(12'h01C, d); check("R8", "timer value untouched", d, 0);
        @(negedge clk);
        check("R9", "rdata idle zero", bus_rdata, 0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_expiry();
        t_gating();
        t_local_bus();
        t_ipi();
        t_misc();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule